// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller. By default it serves two banks of 32 pins. Software reaches it over a plain 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. Each pin has a direction bit, which drives the output-enable. Each pin also has an output level, changed only through write-one set and clear ports. The pin's input level is read through a two-flop synchronizer, whatever the pin's direction.

Every pin can flag rising edges, falling edges or both into a sticky status word. Software clears that word by writing ones. The status of each bank is folded into 16-pin interrupt groups, two per bank. Each group drives one level interrupt line, gated by a bit in a shared group-enable register. An interrupt service routine reads a bank's status, writes the same value back to acknowledge it, and the line drops unless new edges have arrived.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, every pin is an input (`pin_oe` all 0), `pin_out` is all 0, and all edge enables, status bits, group enables and `grp_irq` are 0. The direction register reads all ones.
- R2: Each bank's direction register is at bank word 0 and is fully writable. A bit of 1 makes the pin an input (`pin_oe` bit 0). A bit of 0 makes it an output (`pin_oe` bit 1).
- R3: Writing ones at bank word 2 sets those output bits, and writing ones at word 3 clears them. Zero bits leave outputs unchanged. The output data register at word 1 reads the current outputs and ignores writes. Words 2 and 3 read as zero.
- R4: The input data register at word 4 returns the pin level after a two-flop synchronizer, so a pin change is first visible two clock edges later. This holds for input and output pins alike.
- R5: Rising-edge enables are set by ones written at word 5 and cleared by ones written at word 6. Falling-edge enables are set at word 7 and cleared at word 8. Words 5 and 7 read back the current enable masks, and words 6 and 8 read as zero.
- R6: A status bit (word 9) is set only by an edge whose type is enabled for that pin. With both types enabled, either edge sets it. The bit is set on the third clock edge after the pin changes.
- R7: Writing ones to the status word clears those bits. Zero bits leave status unchanged, and status never clears without a write.
- R8: If an edge is detected in the same cycle that a write of one clears that status bit, the bit stays set.
- R9: The group-enable register is at byte address 0x08, and bit k gates group k. Group 2b is bits 15:0 of bank b's status, and group 2b+1 is bits 31:16. `grp_irq[k]` is 1 exactly while its enable is 1 and any of its 16 status bits is set.
- R10: Bank b's ten registers start at byte address 0x10 + 0x28*b, at consecutive word offsets. Any other address reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 64 | Asynchronous pin levels, bank 0 in the low word |
| pin_out | output | 64 | Output data levels |
| pin_oe | output | 64 | Output enable, 1 where the direction bit is 0 |
| grp_irq | output | 4 | Level interrupt per 16-pin group |

## Verification
The bench uses the default parameters: two 32-pin banks, 16-pin groups and an 8-bit address. With these values the second bank sits at a stride-decoded base of 0x38. All four group lines are exercised, so both halves of each bank's status map to distinct interrupts. Random 64-bit pin patterns, enable changes, acknowledges and group-enable writes are checked against a bench model of status and group lines. Directed cases cover synchronizer latency, read-only and read-as-zero words, unmapped addresses, and an edge that lands in the same cycle as its acknowledge.

// File: rtl/gpio_ctrl_pkg.sv
`timescale 1ns/1ps
// Shared address-map constants and bank register index type.
package gpio_ctrl_pkg;
    localparam int REG_WORDS   = 10;
    localparam int GRP_EN_ADDR = 'h08;
    localparam int BANK_BASE   = 'h10;
    localparam int BANK_STRIDE = 'h28;

    // Word index inside one bank block; the order is the address layout.
    typedef enum logic [3:0] {
        RG_DIR  = 4'd0,
        RG_DOUT = 4'd1,
        RG_DSET = 4'd2,
        RG_DCLR = 4'd3,
        RG_DIN  = 4'd4,
        RG_RSET = 4'd5,
        RG_RCLR = 4'd6,
        RG_FSET = 4'd7,
        RG_FCLR = 4'd8,
        RG_STAT = 4'd9
    } bank_reg_e;
endpackage

// File: rtl/gpio_pin_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer with one-cycle-delayed copy for edge detection.
// Assumes pins are quasi-static relative to clk; resets to all zero.
module gpio_pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_async,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    // First synchronizer stage
    always_ff @(posedge clk) begin
        if (!rst_n) meta_q <= '0;
        else        meta_q <= pin_async;
    end

    // Second synchronizer stage
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= meta_q;
    end

    // Previous synchronized value for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_q;
    end

    // Edge flags from current and previous synchronized levels
    always_comb begin
        level = sync_q;
        rise  = sync_q & ~prev_q;
        fall  = ~sync_q & prev_q;
    end
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
// One GPIO bank: direction, write-one set/clear outputs and edge enables,
// synchronized input, and sticky write-one-to-clear edge status.
// Assumes sel/idx are decoded by the parent; one access per cycle.
module gpio_bank
    import gpio_ctrl_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel,
    input  bank_reg_e    idx,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pins,
    output logic [W-1:0] rdata,
    output logic [W-1:0] dout,
    output logic [W-1:0] dir,
    output logic [W-1:0] status,
    output logic [W-1:0] edge_hit
);
    logic [W-1:0] level, rise, fall;
    logic [W-1:0] rise_en_q, fall_en_q;
    logic         wr;

    gpio_pin_sync #(.W(W)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pins),
        .level     (level),
        .rise      (rise),
        .fall      (fall)
    );

    // Write qualifier and enabled-edge vector
    always_comb begin
        wr       = sel && we;
        edge_hit = (rise & rise_en_q) | (fall & fall_en_q);
    end

    // Direction register, 1 = input
    always_ff @(posedge clk) begin
        if (!rst_n)                   dir <= '1;
        else if (wr && idx == RG_DIR) dir <= wdata;
    end

    // Output data via set and clear ports
    always_ff @(posedge clk) begin
        if (!rst_n)                    dout <= '0;
        else if (wr && idx == RG_DSET) dout <= dout | wdata;
        else if (wr && idx == RG_DCLR) dout <= dout & ~wdata;
    end

    // Rising-edge enable mask
    always_ff @(posedge clk) begin
        if (!rst_n)                    rise_en_q <= '0;
        else if (wr && idx == RG_RSET) rise_en_q <= rise_en_q | wdata;
        else if (wr && idx == RG_RCLR) rise_en_q <= rise_en_q & ~wdata;
    end

    // Falling-edge enable mask
    always_ff @(posedge clk) begin
        if (!rst_n)                    fall_en_q <= '0;
        else if (wr && idx == RG_FSET) fall_en_q <= fall_en_q | wdata;
        else if (wr && idx == RG_FCLR) fall_en_q <= fall_en_q & ~wdata;
    end

    // Sticky status; a new edge overrides a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~((wr && idx == RG_STAT) ? wdata : '0)) | edge_hit;
    end

    // Read-back multiplexer
    always_comb begin
        unique case (idx)
            RG_DIR:  rdata = dir;
            RG_DOUT: rdata = dout;
            RG_DIN:  rdata = level;
            RG_RSET: rdata = rise_en_q;
            RG_FSET: rdata = fall_en_q;
            RG_STAT: rdata = status;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_fold.sv
`timescale 1ns/1ps
// Folds concatenated bank status into per-group level interrupts.
// Assumes group g covers status bits [g*GROUP_W +: GROUP_W].
module gpio_irq_fold #(
    parameter int NUM_GROUPS = 4,
    parameter int GROUP_W    = 16
) (
    input  logic [NUM_GROUPS*GROUP_W-1:0] status_all,
    input  logic [NUM_GROUPS-1:0]         grp_en,
    output logic [NUM_GROUPS-1:0]         grp_irq
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_fold
        // OR-reduce the group's status, gated by its enable
        always_comb grp_irq[g] = grp_en[g] && (|status_all[g*GROUP_W +: GROUP_W]);
    end
endmodule

// File: rtl/gpio_ctrl.sv
`timescale 1ns/1ps
// Banked GPIO controller top: address decode, bank instances,
// group-enable register and group interrupt fold.
// Assumes bus data width equals bank width and one access per cycle.
module gpio_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 32,
    parameter int GROUP_W   = 16,
    parameter int ADDR_W    = 8
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [ADDR_W-1:0]                         bus_addr,
    input  logic                                      bus_we,
    input  logic [BANK_W-1:0]                         bus_wdata,
    output logic [BANK_W-1:0]                         bus_rdata,
    input  logic [NUM_BANKS*BANK_W-1:0]               pin_in,
    output logic [NUM_BANKS*BANK_W-1:0]               pin_out,
    output logic [NUM_BANKS*BANK_W-1:0]               pin_oe,
    output logic [NUM_BANKS*(BANK_W/GROUP_W)-1:0]     grp_irq
);
    localparam int GRPS_PER_BANK = BANK_W / GROUP_W;
    localparam int NUM_GROUPS    = NUM_BANKS * GRPS_PER_BANK;
    localparam int PIN_W         = NUM_BANKS * BANK_W;

    logic [NUM_BANKS-1:0]  bank_hit;
    logic [BANK_W-1:0]     bank_rd [NUM_BANKS];
    logic [PIN_W-1:0]      dir_all;
    logic [PIN_W-1:0]      status_all;
    logic [PIN_W-1:0]      edge_all;
    logic [NUM_GROUPS-1:0] grp_en_q;
    logic                  grp_hit;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int BASE = BANK_BASE + b * BANK_STRIDE;
        logic [ADDR_W-1:0] off;

        // Offset within this bank's block and hit decode
        always_comb begin
            off         = bus_addr - ADDR_W'(BASE);
            bank_hit[b] = (int'(bus_addr) >= BASE) && (int'(off) < REG_WORDS * 4)
                          && (off[1:0] == 2'b00);
        end

        gpio_bank #(.W(BANK_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (bank_hit[b]),
            .idx      (bank_reg_e'(off[5:2])),
            .we       (bus_we),
            .wdata    (bus_wdata),
            .pins     (pin_in[b*BANK_W +: BANK_W]),
            .rdata    (bank_rd[b]),
            .dout     (pin_out[b*BANK_W +: BANK_W]),
            .dir      (dir_all[b*BANK_W +: BANK_W]),
            .status   (status_all[b*BANK_W +: BANK_W]),
            .edge_hit (edge_all[b*BANK_W +: BANK_W])
        );
    end

    // Output enable is the inverse of the input-direction bit
    always_comb pin_oe = ~dir_all;

    // Group-enable register address match
    always_comb grp_hit = (int'(bus_addr) == GRP_EN_ADDR);

    // Group-enable register
    always_ff @(posedge clk) begin
        if (!rst_n)                grp_en_q <= '0;
        else if (bus_we && grp_hit) grp_en_q <= bus_wdata[NUM_GROUPS-1:0];
    end

    // Read-data multiplexer; unmapped addresses read zero
    always_comb begin
        bus_rdata = '0;
        if (grp_hit) bus_rdata = BANK_W'(grp_en_q);
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) bus_rdata = bank_rd[b];
        end
    end

    gpio_irq_fold #(.NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W)) u_fold (
        .status_all (status_all),
        .grp_en     (grp_en_q),
        .grp_irq    (grp_irq)
    );
endmodule

// File: rtl/gpio_ctrl_chk.sv
`timescale 1ns/1ps
// Assertion checker for gpio_ctrl, attached by bind.
// Assumes status_all / edge_all are bank-major concatenations.
module gpio_ctrl_chk #(
    parameter int PIN_W      = 64,
    parameter int NUM_GROUPS = 4,
    parameter int GROUP_W    = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_we,
    input logic [PIN_W-1:0]      pin_out,
    input logic [PIN_W-1:0]      pin_oe,
    input logic [NUM_GROUPS-1:0] grp_irq,
    input logic [NUM_GROUPS-1:0] grp_en,
    input logic [PIN_W-1:0]      status_all,
    input logic [PIN_W-1:0]      edge_all
);
    // R3: outputs move only on a bus write
    a_r3_out_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pin_out));

    // R2: output enables move only on a bus write
    a_r2_oe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pin_oe));

    // R6: a status bit rises only where an enabled edge was seen
    a_r6_set_by_edge: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_all & ~$past(status_all) & ~$past(edge_all)) == '0));

    // R8: an enabled edge always lands in status, even against a clear
    a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(edge_all) & ~status_all) == '0));

    // R7: status bits drop only after a bus write
    a_r7_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status_all) & ~status_all) == '0) || $past(bus_we)));

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        // R9: a group line needs its enable and a pending status bit
        a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
            grp_irq[g] |-> (grp_en[g] && (status_all[g*GROUP_W +: GROUP_W] != '0)));
    end
endmodule

bind gpio_ctrl gpio_ctrl_chk #(
    .PIN_W      (PIN_W),
    .NUM_GROUPS (NUM_GROUPS),
    .GROUP_W    (GROUP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .grp_irq    (grp_irq),
    .grp_en     (grp_en_q),
    .status_all (status_all),
    .edge_all   (edge_all)
);

// File: tb/sim_gpio_ctrl.sv
`timescale 1ns/1ps
// Self-checking bench for gpio_ctrl: directed corners plus seeded random.
module sim_gpio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] pin_in = '0;
    logic [63:0] pin_out, pin_oe;
    logic [3:0]  grp_irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_rise [2];
    logic [31:0] m_fall [2];
    logic [31:0] m_stat [2];
    logic [3:0]  m_gen;

    gpio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .grp_irq(grp_irq)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] ra(input int bank, input int idx);
        return 8'('h10 + bank * 'h28 + idx * 4);
    endfunction

    function automatic logic [3:0] exp_irq();
        logic [3:0] r;
        for (int g = 0; g < 4; g++)
            r[g] = m_gen[g] && ((g % 2 == 0) ? (m_stat[g/2][15:0] != 0) : (m_stat[g/2][31:16] != 0));
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_rd(a, d);
        chk(tag, {32'h0, d}, {32'h0, exp});
    endtask

    task automatic set_pins(input logic [63:0] p);
        logic [63:0] old;
        old = pin_in;
        @(negedge clk);
        pin_in = p;
        repeat (4) @(posedge clk);
        for (int b = 0; b < 2; b++) begin
            logic [31:0] o, n;
            o = old[b*32 +: 32];
            n = p[b*32 +: 32];
            m_stat[b] = m_stat[b] | ((n & ~o) & m_rise[b]) | ((o & ~n) & m_fall[b]);
        end
    endtask

    initial begin : watchdog
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        void'($urandom(32'd4711));
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        #1;
        chk("R1 pin_oe", pin_oe, 64'h0);
        chk("R1 pin_out", pin_out, 64'h0);
        chk("R1 grp_irq", {60'h0, grp_irq}, 64'h0);
        rd_chk("R1 dir", ra(0, 0), 32'hFFFF_FFFF);
        rd_chk("R1 status", ra(1, 9), 32'h0);
        rd_chk("R1 grp_en", 8'h08, 32'h0);
        rd_chk("R1 rise_en", ra(0, 5), 32'h0);

        // R2 direction
        bus_wr(ra(0, 0), 32'hFFFF_0000);
        bus_wr(ra(1, 0), 32'h0000_0000);
        @(negedge clk);
        chk("R2 pin_oe", pin_oe, 64'hFFFF_FFFF_0000_FFFF);
        rd_chk("R2 dir readback", ra(0, 0), 32'hFFFF_0000);

        // R3 set/clear outputs
        bus_wr(ra(0, 2), 32'h0000_00F0);
        bus_wr(ra(0, 2), 32'h0000_000F);
        bus_wr(ra(0, 3), 32'h0000_0030);
        bus_wr(ra(0, 1), 32'h1234_5678);
        bus_wr(ra(1, 2), 32'h8000_0001);
        @(negedge clk);
        chk("R3 pin_out", pin_out, 64'h8000_0001_0000_00CF);
        rd_chk("R3 dout read", ra(0, 1), 32'h0000_00CF);
        rd_chk("R3 set port zero", ra(0, 2), 32'h0);
        rd_chk("R3 clr port zero", ra(0, 3), 32'h0);

        // R4 synchronizer latency, output pins included
        @(negedge clk);
        pin_in = 64'h0F0F_0000_A5A5_3C3C;
        @(posedge clk);
        @(negedge clk) bus_addr = ra(0, 4);
        #1 chk("R4 din after one edge", {32'h0, bus_rdata}, 64'h0);
        @(posedge clk);
        @(negedge clk) bus_addr = ra(0, 4);
        #1 chk("R4 din after two edges", {32'h0, bus_rdata}, 64'h0000_0000_A5A5_3C3C);
        rd_chk("R4 din bank1", ra(1, 4), 32'h0F0F_0000);
        repeat (2) @(posedge clk);
        rd_chk("R6 no edge without enable", ra(0, 9), 32'h0);

        // R5 edge enables
        bus_wr(ra(0, 5), 32'h0000_FFFF);
        bus_wr(ra(0, 6), 32'h0000_00FF);
        rd_chk("R5 rise mask", ra(0, 5), 32'h0000_FF00);
        rd_chk("R5 rise clr reads zero", ra(0, 6), 32'h0);
        bus_wr(ra(1, 7), 32'hF0F0_F0F0);
        rd_chk("R5 fall mask", ra(1, 7), 32'hF0F0_F0F0);
        rd_chk("R5 fall clr reads zero", ra(1, 8), 32'h0);

        // R10 address map and unmapped access
        bus_wr(8'h60, 32'hFFFF_FFFF);
        bus_wr(8'h00, 32'hFFFF_FFFF);
        rd_chk("R10 unmapped 0x60", 8'h60, 32'h0);
        rd_chk("R10 unmapped 0x04", 8'h04, 32'h0);
        rd_chk("R10 bank1 dir at 0x38", 8'h38, 32'h0);
        rd_chk("R10 bank0 dir kept", 8'h10, 32'hFFFF_0000);
        chk("R10 pin_out kept", pin_out, 64'h8000_0001_0000_00CF);

        // Clean state for model-based phase
        for (int b = 0; b < 2; b++) begin
            bus_wr(ra(b, 6), 32'hFFFF_FFFF);
            bus_wr(ra(b, 8), 32'hFFFF_FFFF);
            bus_wr(ra(b, 9), 32'hFFFF_FFFF);
            m_rise[b] = '0; m_fall[b] = '0; m_stat[b] = '0;
        end
        m_gen = '0;

        // R8 edge wins over same-cycle clear
        bus_wr(ra(0, 5), 32'h0010_0000);
        bus_wr(ra(0, 7), 32'h0010_0000);
        m_rise[0] = 32'h0010_0000; m_fall[0] = 32'h0010_0000;
        set_pins(pin_in & ~64'h0010_0000);
        bus_wr(ra(0, 9), 32'hFFFF_FFFF);
        m_stat[0] = '0;
        set_pins(pin_in | 64'h0010_0000);
        rd_chk("R6 rise sets status", ra(0, 9), m_stat[0]);
        @(negedge clk) pin_in[20] = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk) begin bus_addr = ra(0, 9); bus_we = 1'b1; bus_wdata = 32'h0010_0000; end
        @(posedge clk);
        #1 bus_we = 1'b0;
        rd_chk("R8 edge beats clear", ra(0, 9), 32'h0010_0000);
        bus_wr(ra(0, 9), 32'h0010_0000);
        rd_chk("R7 clear by write one", ra(0, 9), 32'h0);
        m_stat[0] = '0;

        // R9 group enable readback
        bus_wr(8'h08, 32'h0000_0005);
        rd_chk("R9 grp_en readback", 8'h08, 32'h5);
        m_gen = 4'h5;

        // Random phase: R6 R7 R9
        for (int it = 0; it < 80; it++) begin
            int op;
            int b;
            logic [31:0] r;
            op = $urandom_range(0, 4);
            b  = $urandom_range(0, 1);
            r  = $urandom;
            case (op)
                0, 1: set_pins({$urandom, $urandom});
                2: begin
                    case ($urandom_range(0, 3))
                        0: begin bus_wr(ra(b, 5), r); m_rise[b] = m_rise[b] | r; end
                        1: begin bus_wr(ra(b, 6), r); m_rise[b] = m_rise[b] & ~r; end
                        2: begin bus_wr(ra(b, 7), r); m_fall[b] = m_fall[b] | r; end
                        default: begin bus_wr(ra(b, 8), r); m_fall[b] = m_fall[b] & ~r; end
                    endcase
                end
                3: begin bus_wr(ra(b, 9), r); m_stat[b] = m_stat[b] & ~r; end
                default: begin bus_wr(8'h08, r); m_gen = r[3:0]; end
            endcase
            rd_chk("R6 R7 status bank0", ra(0, 9), m_stat[0]);
            rd_chk("R6 R7 status bank1", ra(1, 9), m_stat[1]);
            chk("R9 grp_irq", {60'h0, grp_irq}, {60'h0, exp_irq()});
        end

        // R9 re-assert after acknowledge when new edge arrives
        bus_wr(8'h08, 32'hF);
        m_gen = 4'hF;
        bus_wr(ra(1, 5), 32'h0001_0000);
        m_rise[1] = m_rise[1] | 32'h0001_0000;
        bus_wr(ra(1, 9), 32'hFFFF_FFFF);
        m_stat[1] = '0;
        set_pins(pin_in & ~64'h0001_0000_0000_0000);
        bus_wr(ra(1, 9), 32'hFFFF_FFFF);
        m_stat[1] = '0;
        @(negedge clk);
        chk("R9 group3 low after ack", {63'h0, grp_irq[3]}, 64'h0);
        set_pins(pin_in | 64'h0001_0000_0000_0000);
        @(negedge clk);
        chk("R9 group3 re-asserts", {63'h0, grp_irq[3]}, 64'h1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule